// File: doc/BRIEF.md
# Cache Valid-Bit Invalidate Sequencer

This block clears a cache's valid array in a controlled sweep. Software writes the control register with the invalidate command bit set. The sequencer then steps through every set of the valid array. It issues one clear strobe per clock, with the set index counting upward from zero. During the sweep a stall output holds off all local-bus accesses. When the last set has been cleared, the command bit drops by itself and the stall is released. Software never has to write the bit back to zero.

The command bit reads back as 1 for as long as the sweep runs, so software can poll it to see when the sweep is done. A second command that arrives during a sweep is dropped. Reset only returns the sequencer to idle. It never starts a sweep, so a power-up or ordinary reset leaves the valid array as it was.

Top module: `inv_walk_ctrl`

## Requirements
- R1: A write sampled while idle with bit INV_BIT (default 0) of the write data at 1 starts a sweep. In the next cycle `vld_clr_stb` and `bus_stall` are 1 and `vld_clr_idx` is 0. The other data bits have no effect.
- R2: A write sampled while idle with bit INV_BIT at 0 does not start a sweep, whatever the other bits hold. `bus_stall` and `vld_clr_stb` stay 0.
- R3: During a sweep, `vld_clr_stb` is 1 in every cycle and `vld_clr_idx` rises by exactly one per cycle from 0 to NUM_SETS-1. This gives exactly NUM_SETS strobes per sweep.
- R4: `bus_stall` is 1 from the cycle after the starting write through the cycle in which set NUM_SETS-1 is strobed. It is 0 in the following cycle.
- R5: Bit INV_BIT of `cfg_rd_data` reads 1 in every cycle of a sweep and 0 otherwise. It clears itself in the cycle after the last set is strobed. All other readback bits are always 0.
- R6: A command write sampled during a sweep, including one sampled on the final sweep cycle, is ignored. It neither restarts nor lengthens the sweep.
- R7: In the cycle after a cycle with `rst` high, `bus_stall`, `vld_clr_stb` and the readback are 0. Reset never causes a clear strobe, and a reset during a sweep ends it with no further strobes.
- R8: A command written in the first idle cycle after a sweep starts a new full sweep from set 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | CTRL_W | Control register write data |
| cfg_rd_data | output | CTRL_W | Control register readback |
| vld_clr_stb | output | 1 | Clear strobe to the valid array |
| vld_clr_idx | output | $clog2(NUM_SETS) | Set index to clear |
| bus_stall | output | 1 | Hold-off for local-bus accesses |

## Verification
The embedded properties check the following on every cycle:
- a command accepted while idle starts at set 0;
- a cleared command bit leaves the sequencer idle;
- the index steps by one during a sweep, even when further commands arrive;
- the stall falls only after the last set or after reset;
- the readback bit matches the stall.

Only the bench scenarios can show that a whole sweep has exactly NUM_SETS strobes and ends in the expected cycle. They also show that a command on the very last sweep cycle is dropped, that reset mid-sweep stops the strobes for good, and that a back-to-back command starts a fresh sweep.

// File: rtl/inv_walk_pkg.sv
package inv_walk_pkg;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_BUSY = 1'b1
    } walk_state_e;

    typedef struct packed {
        logic strobe;
        logic stall;
    } walk_status_t;

    // A command is accepted only when the sequencer is idle.
    function automatic logic accept_cmd(input logic wr_en,
                                        input logic cmd_bit,
                                        input walk_state_e st);
        return wr_en && cmd_bit && (st == WALK_IDLE);
    endfunction

    function automatic logic at_last_set(input int unsigned idx,
                                         input int unsigned num_sets);
        return idx == (num_sets - 1);
    endfunction

endpackage

// File: rtl/inv_cmd_port.sv
module inv_cmd_port
    import inv_walk_pkg::*;
#(
    parameter int unsigned CTRL_W  = 8,
    parameter int unsigned INV_BIT = 0
) (
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  walk_state_e       walk_st,
    output logic              start,
    output logic [CTRL_W-1:0] rd_data
);

    always_comb begin
        start = accept_cmd(wr_en, wr_data[INV_BIT], walk_st);
    end

    // Readback: the command bit mirrors the sweep state; all other bits are zero.
    always_comb begin
        rd_data          = '0;
        rd_data[INV_BIT] = (walk_st == WALK_BUSY);
    end

endmodule

// File: rtl/inv_set_walker.sv
module inv_set_walker
    import inv_walk_pkg::*;
#(
    parameter int unsigned NUM_SETS = 512,
    parameter int unsigned IDX_W    = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output walk_state_e      walk_st,
    output logic [IDX_W-1:0] idx,
    output walk_status_t     status
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SETS - 1);

    walk_state_e      st_q;
    logic [IDX_W-1:0] idx_q;
    logic             last;

    always_comb begin
        last = at_last_set(32'(idx_q), NUM_SETS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= WALK_IDLE;
            idx_q <= '0;
        end else begin
            case (st_q)
                WALK_IDLE: begin
                    if (start) begin
                        st_q  <= WALK_BUSY;
                        idx_q <= '0;
                    end
                end
                WALK_BUSY: begin
                    if (last) begin
                        st_q  <= WALK_IDLE;
                        idx_q <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: begin
                    st_q  <= WALK_IDLE;
                    idx_q <= '0;
                end
            endcase
        end
    end

    always_comb begin
        walk_st       = st_q;
        idx           = idx_q;
        status.strobe = (st_q == WALK_BUSY);
        status.stall  = (st_q == WALK_BUSY);
    end

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (status.strobe && idx_q != LAST_IDX) |=> (status.strobe && idx_q == $past(idx_q) + 1'b1));

    // R4
    stall_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(status.stall) && !$past(rst)) |-> ($past(idx_q) == LAST_IDX));

endmodule

// File: rtl/inv_walk_ctrl.sv
module inv_walk_ctrl
    import inv_walk_pkg::*;
#(
    parameter int unsigned NUM_SETS = 512,
    parameter int unsigned CTRL_W   = 8,
    parameter int unsigned INV_BIT  = 0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_wr_en,
    input  logic [CTRL_W-1:0]           cfg_wr_data,
    output logic [CTRL_W-1:0]           cfg_rd_data,
    output logic                        vld_clr_stb,
    output logic [$clog2(NUM_SETS)-1:0] vld_clr_idx,
    output logic                        bus_stall
);

    localparam int unsigned       IDX_W    = $clog2(NUM_SETS);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_SETS - 1);
    localparam logic [CTRL_W-1:0] CMD_MASK = CTRL_W'(1) << INV_BIT;

    walk_state_e      walk_st;
    walk_status_t     status;
    logic             start;
    logic [IDX_W-1:0] idx;

    inv_cmd_port #(
        .CTRL_W  (CTRL_W),
        .INV_BIT (INV_BIT)
    ) u_cmd (
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .walk_st (walk_st),
        .start   (start),
        .rd_data (cfg_rd_data)
    );

    inv_set_walker #(
        .NUM_SETS (NUM_SETS),
        .IDX_W    (IDX_W)
    ) u_walk (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .walk_st (walk_st),
        .idx     (idx),
        .status  (status)
    );

    always_comb begin
        vld_clr_stb = status.strobe;
        vld_clr_idx = idx;
        bus_stall   = status.stall;
    end

    // R1
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_stall && cfg_wr_en && cfg_wr_data[INV_BIT]) |=> (bus_stall && vld_clr_stb && vld_clr_idx == '0));

    // R2
    no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_stall && !(cfg_wr_en && cfg_wr_data[INV_BIT])) |=> (!bus_stall && !vld_clr_stb));

    // R5
    readback_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd_data[INV_BIT] == bus_stall) && ((cfg_rd_data & ~CMD_MASK) == '0));

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_stall && cfg_wr_en && cfg_wr_data[INV_BIT] && vld_clr_idx != LAST_IDX)
            |=> (bus_stall && vld_clr_idx == $past(vld_clr_idx) + 1'b1));

    // R7
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!bus_stall && !vld_clr_stb && cfg_rd_data == '0));

endmodule

// File: tb/test_inv_walk_ctrl.sv
module test_inv_walk_ctrl;

    localparam int unsigned SETS   = 8;
    localparam int unsigned CW     = 8;
    localparam int unsigned CB     = 5;
    localparam int unsigned IW     = $clog2(SETS);

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_wr_en;
    logic [CW-1:0] cfg_wr_data;
    logic [CW-1:0] cfg_rd_data;
    logic          vld_clr_stb;
    logic [IW-1:0] vld_clr_idx;
    logic          bus_stall;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    always #10 clk = ~clk;

    inv_walk_ctrl #(
        .NUM_SETS (SETS),
        .CTRL_W   (CW),
        .INV_BIT  (CB)
    ) i_inv_walk_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .vld_clr_stb (vld_clr_stb),
        .vld_clr_idx (vld_clr_idx),
        .bus_stall   (bus_stall)
    );

    task automatic chk(input string req, input string what,
                       input int unsigned act, input int unsigned exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check_idle(input string req);
        chk(req, "stall idle", bus_stall, 0);
        chk(req, "strobe idle", vld_clr_stb, 0);
        chk(req, "readback idle", cfg_rd_data, 0);
    endtask

    task automatic write(input logic [CW-1:0] d);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = d;
        step();
        cfg_wr_en   = 1'b0;
        cfg_wr_data = '0;
    endtask

    // Walk check from the first cycle after the starting write.
    // A command of 1 is re-issued at sweep cycle poke (SETS+1 means never).
    task automatic check_walk(input string req, input int unsigned poke);
        for (int unsigned k = 0; k < SETS; k++) begin
            chk(req, "strobe", vld_clr_stb, 1);
            chk("R3", "index", vld_clr_idx, k);
            chk("R4", "stall", bus_stall, 1);
            chk("R5", "readback", cfg_rd_data, 1 << CB);
            if (k == poke) write(8'hFF);
            else step();
        end
        chk("R4", "stall after last", bus_stall, 0);
        chk("R5", "self clear", cfg_rd_data, 0);
        chk("R3", "no extra strobe", vld_clr_stb, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_wr_en = 1'b0; cfg_wr_data = '0;
        #2;
        step(); step();
        // R7: reset state
        check_idle("R7");
        rst = 1'b0;
        step();
        check_idle("R7");

        // R2: every data pattern with the command bit clear
        for (int d = 0; d < 256; d++) begin
            if (d[CB] == 1'b0) begin
                write(CW'(d));
                chk("R2", "stall", bus_stall, 0);
                chk("R2", "strobe", vld_clr_stb, 0);
            end
        end

        // R1: command alone, then command with all bits set
        write(CW'(1) << CB);
        check_walk("R1", SETS + 1);
        write(8'hFF);
        check_walk("R1", SETS + 1);

        // R6: command re-issued at every sweep cycle, including the last
        for (int unsigned p = 0; p < SETS; p++) begin
            write(CW'(1) << CB);
            check_walk("R6", p);
            chk("R6", "no restart stall", bus_stall, 0);
            step();
            chk("R6", "still idle", bus_stall, 0);
        end

        // R8: back-to-back sweeps
        write(CW'(1) << CB);
        check_walk("R8", SETS + 1);
        write(CW'(1) << CB);
        check_walk("R8", SETS + 1);

        // R7: reset during a sweep aborts with no further strobes
        write(CW'(1) << CB);
        step(); step();
        chk("R7", "mid sweep stall", bus_stall, 1);
        rst = 1'b1;
        step();
        check_idle("R7");
        rst = 1'b0;
        for (int i = 0; i < SETS + 2; i++) begin
            step();
            check_idle("R7");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule